// File: doc/BRIEF.md
# Vector Lane Single-Bit Modify Unit

This execution unit works on a 256-bit vector split into equal element lanes of 8, 16, 32 or 64 bits. For each lane it changes exactly one bit of the first source operand, and it does the same in every lane at once. The bit can be cleared, set or inverted. The unit decodes the 32-bit instruction word itself. It then returns the modified vector one clock later, along with the destination register index taken from the word.

The bit position can come from two places. In the register form, each lane takes its position from the same lane of a second source vector, reduced modulo the lane width. In the immediate form, one unsigned field in the instruction gives the position for all lanes. That field is 3, 4, 5 or 6 bits wide, to match the lane size. A word that decodes as none of the 24 variants raises an illegal flag instead of producing a result.

Top module: `vbit_lane_unit`

## Requirements
- R1: Clear: each result lane equals the source lane with the selected bit forced to 0. In the register form it is selected by bits [17:15] = {0,size}, and in the immediate form by operation bits [19:18] = 00.
- R2: Set: each result lane equals the source lane with the selected bit forced to 1. In the register form it is selected by bits [17:15] = {1,size}, and in the immediate form by operation bits [19:18] = 01.
- R3: Flip: each result lane equals the source lane with the selected bit inverted. In the register form it is selected by bits [31:17] = 011101010001000 with size in [16:15], and in the immediate form by operation bits [19:18] = 10.
- R4: Size code 0/1/2/3 selects 8/16/32/64-bit lanes. There are 32/16/8/4 lanes, with lane i in bits [i*W+W-1 : i*W], and each lane is computed only from its own bits.
- R5: In the register form, the bit position for a lane is the same lane of src_b taken modulo the lane width. All higher bits of that lane have no effect.
- R6: In the immediate form, bits [31:20] = 011101110001. Bits [17:10] are 00001iii for bytes, 0001iiii for halfwords, 001iiiii for words and 01iiiiii for doublewords, with the position in the i bits. That position applies to every lane.
- R7: The register form is recognised when bits [31:18] = 01110101000011 (clear/set), or through the flip pattern of R3.
- R8: The destination index in bits [4:0] appears on out_dest with the result. The first source vector is src_a, and the second is src_b.
- R9: A word accepted with in_valid that matches no variant gives out_illegal = 1, out_valid = 0 and out_result = 0 one cycle later. This includes immediate operation 11, register flip with bit 17 set, and a bad immediate size field.
- R10: Latency is one cycle. A cycle without in_valid is followed by out_valid = 0, out_illegal = 0 and out_result = 0.
- R11: Synchronous active-high reset clears out_valid, out_illegal, out_result and out_dest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands present |
| instr | input | 32 | Instruction word |
| src_a | input | 256 | Vector whose lanes are modified |
| src_b | input | 256 | Per-lane bit positions (register form) |
| out_valid | output | 1 | Result valid |
| out_illegal | output | 1 | Instruction word not recognised |
| out_result | output | 256 | Modified vector |
| out_dest | output | 5 | Destination register index |

## Verification
The only state is the output register, so a fault inside the unit shows up at the ports on the very next cycle. A decode error swaps the operation or lane size, or flags a legal word as illegal. An error in the index path marks the wrong bit in one or more lanes, and the bench finds it by comparing against a bit-by-bit model. Index values at and above the lane width, together with every immediate value, expose a faulty modulo reduction or a truncated immediate field in the first result that uses it.

// File: rtl/vbit_lane_unit.sv
module vbit_lane_unit #(
  parameter int DATA_W = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              out_valid,
  output logic              out_illegal,
  output logic [DATA_W-1:0] out_result,
  output logic [4:0]        out_dest
);
  typedef enum logic [1:0] {OP_CLR = 2'd0, OP_SET = 2'd1, OP_FLIP = 2'd2} bop_t;

  logic       dec_ok, imm_form;
  bop_t       op;
  logic [1:0] sz;
  logic [5:0] imm_val;

  always_comb begin
    dec_ok   = 1'b0;
    imm_form = 1'b0;
    op       = OP_CLR;
    sz       = 2'd0;
    imm_val  = 6'd0;
    if (instr[31:18] == 14'b01110101000011) begin
      dec_ok = 1'b1;
      op     = instr[17] ? OP_SET : OP_CLR;
      sz     = instr[16:15];
    end else if (instr[31:17] == 15'b011101010001000) begin
      dec_ok = 1'b1;
      op     = OP_FLIP;
      sz     = instr[16:15];
    end else if (instr[31:20] == 12'b011101110001 && instr[19:18] != 2'b11) begin
      imm_form = 1'b1;
      op       = bop_t'(instr[19:18]);
      if (instr[17:16] == 2'b01) begin
        dec_ok = 1'b1; sz = 2'd3; imm_val = instr[15:10];
      end else if (instr[17:15] == 3'b001) begin
        dec_ok = 1'b1; sz = 2'd2; imm_val = {1'b0, instr[14:10]};
      end else if (instr[17:14] == 4'b0001) begin
        dec_ok = 1'b1; sz = 2'd1; imm_val = {2'b0, instr[13:10]};
      end else if (instr[17:13] == 5'b00001) begin
        dec_ok = 1'b1; sz = 2'd0; imm_val = {3'b0, instr[12:10]};
      end
    end
  end

  logic [3:0][DATA_W-1:0] res_by_sz;

  for (genvar s = 0; s < 4; s++) begin : g_sz
    localparam int W  = 8 << s;
    localparam int N  = DATA_W / W;
    localparam int LW = 3 + s;
    for (genvar j = 0; j < N; j++) begin : g_lane
      logic [W-1:0] a_l, pos_l, m_l;
      assign a_l   = src_a[j*W +: W];
      assign pos_l = src_b[j*W +: W] & W'(W-1);
      assign m_l   = imm_form ? (W'(1) << imm_val[LW-1:0]) : (W'(1) << pos_l);
      assign res_by_sz[s][j*W +: W] = (op == OP_CLR) ? (a_l & ~m_l) :
                                      (op == OP_SET) ? (a_l | m_l)  : (a_l ^ m_l);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
      out_dest    <= '0;
    end else begin
      out_valid   <= in_valid && dec_ok;
      out_illegal <= in_valid && !dec_ok;
      out_result  <= (in_valid && dec_ok) ? res_by_sz[sz] : '0;
      if (in_valid) out_dest <= instr[4:0];
    end
  end
endmodule

// File: rtl/vbit_lane_unit_chk.sv
module vbit_lane_unit_chk #(
  parameter int DATA_W = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [3:0]        instr_hi,
  input logic [4:0]        instr_rd,
  input logic              out_valid,
  input logic              out_illegal,
  input logic [DATA_W-1:0] out_result,
  input logic [4:0]        out_dest
);
  // R9
  excl_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_illegal));
  // R9
  bad_prefix_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr_hi != 4'b0111) |=> (out_illegal && out_result == '0));
  // R10
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_illegal && out_result == '0));
  // R8
  dest_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rst) |=> (out_dest == $past(instr_rd)));
  // R11
  reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !out_illegal && out_dest == 5'd0));
endmodule

bind vbit_lane_unit vbit_lane_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .instr_hi(instr[31:28]), .instr_rd(instr[4:0]),
  .out_valid(out_valid), .out_illegal(out_illegal),
  .out_result(out_result), .out_dest(out_dest)
);

// File: tb/vbit_lane_unit_tb.sv
module vbit_lane_unit_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [31:0]  instr = '0;
  logic [255:0] src_a = '0, src_b = '0;
  logic         out_valid, out_illegal;
  logic [255:0] out_result;
  logic [4:0]   out_dest;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  vbit_lane_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
    .out_illegal(out_illegal), .out_result(out_result), .out_dest(out_dest));

  function automatic logic [255:0] model(int op, int size, bit immf, int imm,
                                         logic [255:0] a, logic [255:0] b);
    int w = 8 << size;
    int lw = 3 + size;
    logic [255:0] r = a;
    for (int k = 0; k < 256; k++) begin
      int lane = k / w;
      int idx = 0;
      if (immf) idx = imm;
      else for (int t = 0; t < lw; t++) idx = idx | (int'(b[lane*w + t]) << t);
      if ((k % w) == idx) begin
        if (op == 0) r[k] = 1'b0;
        else if (op == 1) r[k] = 1'b1;
        else r[k] = ~a[k];
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] enc_reg(int op, int size, int d, int j, int k);
    logic [16:0] hi;
    if (op == 2) hi = {15'b011101010001000, 2'(size)};
    else         hi = {14'b01110101000011, 1'(op), 2'(size)};
    return {hi, 5'(k), 5'(j), 5'(d)};
  endfunction

  function automatic logic [31:0] enc_imm(int op, int size, int imm, int j, int d);
    logic [7:0] f;
    case (size)
      0: f = {5'b00001, 3'(imm)};
      1: f = {4'b0001, 4'(imm)};
      2: f = {3'b001, 5'(imm)};
      default: f = {2'b01, 6'(imm)};
    endcase
    return {12'b011101110001, 2'(op), f, 5'(j), 5'(d)};
  endfunction

  function automatic logic [255:0] fill(int size, int v);
    int w = 8 << size;
    logic [255:0] r = '0;
    for (int k = 0; k < 256; k++) r[k] = (k % w) < 32 ? v[(k % w) % 32] : 1'b0;
    return r;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic issue(logic [31:0] w, logic [255:0] a, logic [255:0] b);
    @(negedge clk);
    instr = w; src_a = a; src_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_ok(string req, logic [255:0] exp, logic [4:0] d);
    checks++;
    if (!out_valid || out_illegal || out_result !== exp || out_dest !== d) begin
      fails++;
      $display("FAIL %s: valid=%b ill=%b dest=%0d res=%h exp dest=%0d res=%h",
               req, out_valid, out_illegal, out_dest, out_result, d, exp);
    end
  endtask

  task automatic t_reset();
    checks++;
    if (out_valid !== 1'b0 || out_illegal !== 1'b0 || out_result !== '0 || out_dest !== 5'd0) begin
      fails++;
      $display("FAIL R11: valid=%b ill=%b res=%h dest=%0d exp all zero",
               out_valid, out_illegal, out_result, out_dest);
    end
  endtask

  // R1 R2 R3 R4 R5 R7: register form with random and boundary positions
  task automatic t_reg_form();
    string tags[3] = '{"R1/R7", "R2/R7", "R3/R7"};
    for (int op = 0; op < 3; op++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 4; p++) begin
          logic [255:0] a = rnd256();
          logic [255:0] b;
          int d = (op * 4 + s + p) % 32;
          case (p)
            0: b = rnd256();
            1: b = fill(s, 8 << s);            // R5: equals width -> position 0
            2: b = fill(s, (8 << s) + 3);      // R5: wraps to 3
            default: b = '1;                   // R5: top bit of lane
          endcase
          if (p == 3) a = (op == 1) ? '0 : '1;
          issue(enc_reg(op, s, d, 7, 9), a, b);
          expect_ok({tags[op], " R4 R5 R8"}, model(op, s, 1'b0, 0, a, b), 5'(d));
        end
  endtask

  // R6: immediate form, every position for every size and operation
  task automatic t_imm_form();
    for (int op = 0; op < 3; op++)
      for (int s = 0; s < 4; s++)
        for (int im = 0; im < (8 << s); im++) begin
          logic [255:0] a = rnd256();
          issue(enc_imm(op, s, im, 3, 21), a, rnd256());
          expect_ok("R6 R1 R2 R3 R4", model(op, s, 1'b1, im, a, '0), 5'd21);
        end
  endtask

  // R9: unrecognised words
  task automatic t_illegal();
    logic [31:0] bad[5];
    bad[0] = 32'h0000_0000;
    bad[1] = {15'b011101010001001, 2'd1, 15'h1234};
    bad[2] = {12'b011101110001, 2'b11, 8'b01000001, 10'h0AB};
    bad[3] = {12'b011101110001, 2'b00, 8'b00000101, 10'h055};
    bad[4] = {14'b01110101000111, 3'b000, 15'h0000};
    for (int i = 0; i < 5; i++) begin
      issue(bad[i], '1, '1);
      checks++;
      if (out_valid !== 1'b0 || out_illegal !== 1'b1 || out_result !== '0) begin
        fails++;
        $display("FAIL R9: word %h valid=%b ill=%b res=%h exp valid=0 ill=1 res=0",
                 bad[i], out_valid, out_illegal, out_result);
      end
    end
  endtask

  // R10: idle cycle after a result
  task automatic t_idle();
    issue(enc_reg(1, 0, 4, 1, 2), '0, '0);
    expect_ok("R10", fill(0, 1), 5'd4);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_illegal !== 1'b0 || out_result !== '0) begin
      fails++;
      $display("FAIL R10: idle valid=%b ill=%b res=%h exp 0 0 0",
               out_valid, out_illegal, out_result);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_reg_form();
    t_imm_form();
    t_illegal();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule